// File: doc/BRIEF.md
# Integer ALU for a 64-bit RISC datapath

This block is a purely combinational arithmetic and logic unit for a 64-bit load/store RISC core. It takes two register operands, called the first (rs) and second (rt) operand, plus a 4-bit operation code. It returns a full-width result and a trap indication in the same cycle. It covers five groups of operation: add and subtract on the low 32-bit word, add and subtract on the whole 64-bit doubleword, the four bitwise logic functions, signed and unsigned less-than tests, and a compare that raises a trap when the operands match.

Word-sized arithmetic uses only the low half of each operand. The 32-bit outcome is then widened to 64 bits by copying its top bit. The logic and compare operations always look at every bit. Overflow is never reported: every sum wraps. The surrounding pipeline decodes the instruction, picks the operation code and writes the result back.

Top module: `gp_int_alu`

## Requirements
- R1: With `op_sel` = 0 (word add) the result is the low 32-bit sum of the operands, wrapped, with its bit 31 copied into bits 63..32.
- R2: With `op_sel` = 1 (word subtract) the result is rs minus rt on the low 32 bits, wrapped, with its bit 31 copied into bits 63..32.
- R3: With `op_sel` = 2 the result is the 64-bit sum of rs and rt modulo 2^64. With `op_sel` = 3 the result is rs minus rt modulo 2^64.
- R4: `op_sel` = 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR (inverted OR) of all 64 bits.
- R5: With `op_sel` = 8 the result is 1 when rs is less than rt as 64-bit two's-complement numbers, else 0, with bits 63..1 zero.
- R6: With `op_sel` = 9 the result is 1 when rs is less than rt as 64-bit unsigned numbers, else 0, with bits 63..1 zero.
- R7: With `op_sel` = 10 `trap` is 1 exactly when all 64 bits of rs and rt are equal. The result is zero.
- R8: `trap` is 0 for every `op_sel` other than 10.
- R9: `op_sel` values 11 to 15 give a zero result and `trap` = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| rs_val | input | 64 | First operand |
| rt_val | input | 64 | Second operand |
| result | output | 64 | Operation result |
| trap | output | 1 | Equality trap indication |

## Verification
The bench builds the block with its default 64-bit width, which puts the word/doubleword boundary at bit 31. It crosses twelve corner operands with each other under all sixteen operation codes. The corner set includes zero, one, all-ones, the most negative and most positive values, and patterns with bit 31 set or clear. This pushes carries and borrows across bit 31, where word and doubleword results part ways. It also makes the signed and unsigned less-than tests disagree, and covers equal operands for the trap.

// File: rtl/gp_alu_pkg.sv
package gp_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_WADD  = 4'd0,
        OP_WSUB  = 4'd1,
        OP_DADD  = 4'd2,
        OP_DSUB  = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_NOR   = 4'd7,
        OP_SLT   = 4'd8,
        OP_SLTU  = 4'd9,
        OP_TEQ   = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

    typedef struct packed {
        logic sub;
        logic word;
    } arith_ctl_t;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'd0,
        SEL_ARITH = 3'd1,
        SEL_LOGIC = 3'd2,
        SEL_SLT   = 3'd3,
        SEL_SLTU  = 3'd4
    } res_sel_e;

    typedef struct packed {
        res_sel_e   sel;
        arith_ctl_t arith;
        logic_fn_e  lfn;
        logic       trap_en;
    } alu_dec_t;

    function automatic alu_dec_t decode_op(input logic [OP_W-1:0] op);
        alu_dec_t d;
        d = '{sel: SEL_ZERO, arith: '{sub: 1'b0, word: 1'b0}, lfn: LG_AND, trap_en: 1'b0};
        case (op)
            OP_WADD: begin d.sel = SEL_ARITH; d.arith.word = 1'b1; end
            OP_WSUB: begin d.sel = SEL_ARITH; d.arith.word = 1'b1; d.arith.sub = 1'b1; end
            OP_DADD: d.sel = SEL_ARITH;
            OP_DSUB: begin d.sel = SEL_ARITH; d.arith.sub = 1'b1; end
            OP_AND:  begin d.sel = SEL_LOGIC; d.lfn = LG_AND; end
            OP_OR:   begin d.sel = SEL_LOGIC; d.lfn = LG_OR;  end
            OP_XOR:  begin d.sel = SEL_LOGIC; d.lfn = LG_XOR; end
            OP_NOR:  begin d.sel = SEL_LOGIC; d.lfn = LG_NOR; end
            OP_SLT:  d.sel = SEL_SLT;
            OP_SLTU: d.sel = SEL_SLTU;
            OP_TEQ:  d.trap_en = 1'b1;
            default: d.sel = SEL_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gp_alu_addsub.sv
module gp_alu_addsub
    import gp_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  arith_ctl_t        ctl,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;

    // one shared carry chain: subtract = add inverted operand plus one
    assign b_eff = ctl.sub ? ~b : b;
    assign sum   = a + b_eff + {{(DATA_W-1){1'b0}}, ctl.sub};

    always_comb begin
        if (ctl.word) begin
            y = {{(DATA_W-HALF_W){sum[HALF_W-1]}}, sum[HALF_W-1:0]};
        end else begin
            y = sum;
        end
    end
endmodule

// File: rtl/gp_alu_logic.sv
module gp_alu_logic
    import gp_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic_fn_e         fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] or_v;
    assign or_v = a | b;

    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = or_v;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~or_v;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/gp_alu_cmp.sv
module gp_alu_cmp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              lt_s,
    output logic              lt_u,
    output logic              eq
);
    logic sign_differs;

    assign lt_u         = a < b;
    assign sign_differs = a[DATA_W-1] ^ b[DATA_W-1];
    // with differing signs the negative operand is smaller
    assign lt_s         = sign_differs ? a[DATA_W-1] : lt_u;
    assign eq           = a == b;
endmodule

// File: rtl/gp_int_alu.sv
module gp_int_alu
    import gp_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] result,
    output logic              trap
);
    alu_dec_t          dec;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic              lt_s;
    logic              lt_u;
    logic              eq;

    assign dec = decode_op(op_sel);

    gp_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .ctl (dec.arith),
        .a   (rs_val),
        .b   (rt_val),
        .y   (arith_y)
    );

    gp_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .fn  (dec.lfn),
        .a   (rs_val),
        .b   (rt_val),
        .y   (logic_y)
    );

    gp_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a    (rs_val),
        .b    (rt_val),
        .lt_s (lt_s),
        .lt_u (lt_u),
        .eq   (eq)
    );

    always_comb begin
        case (dec.sel)
            SEL_ARITH: result = arith_y;
            SEL_LOGIC: result = logic_y;
            SEL_SLT:   result = {{(DATA_W-1){1'b0}}, lt_s};
            SEL_SLTU:  result = {{(DATA_W-1){1'b0}}, lt_u};
            default:   result = '0;
        endcase
    end

    assign trap = dec.trap_en & eq;
endmodule

// File: rtl/gp_int_alu_chk.sv
module gp_int_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic [DATA_W-1:0] result,
    input logic              trap
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        if (op_sel <= 4'd1) begin
            AST_WORD_SIGN_FILL: assert (result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result[HALF_W-1]}})
                else $error("word result not sign filled"); // R1
        end
        if (op_sel == 4'd1) begin
            AST_WORD_SUB_LOW: assert (result[HALF_W-1:0] + rt_val[HALF_W-1:0] == rs_val[HALF_W-1:0])
                else $error("word subtract low half wrong"); // R2
        end
        if (op_sel == 4'd2) begin
            AST_DADD_INVERSE: assert (result - rt_val == rs_val)
                else $error("doubleword add wrong"); // R3
        end
        if (op_sel == 4'd7) begin
            AST_NOR_DISJOINT: assert ((result & (rs_val | rt_val)) == '0)
                else $error("nor overlaps operands"); // R4
        end
        if (op_sel == 4'd8 || op_sel == 4'd9) begin
            AST_LT_BOOLEAN: assert (result[DATA_W-1:1] == '0)
                else $error("less-than result not boolean"); // R5
        end
        if (op_sel == 4'd10) begin
            AST_TRAP_ON_MATCH: assert (trap == (rs_val == rt_val) && result == '0)
                else $error("trap compare wrong"); // R7
        end else begin
            AST_TRAP_QUIET: assert (!trap)
                else $error("trap outside compare op"); // R8
        end
        if (op_sel >= 4'd11) begin
            AST_UNUSED_ZERO: assert (result == '0 && !trap)
                else $error("unused code not zero"); // R9
        end
    end
endmodule

bind gp_int_alu gp_int_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel (op_sel),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .result (result),
    .trap   (trap)
);

// File: tb/test_gp_int_alu.sv
module test_gp_int_alu;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_sel = 4'd15;
    logic [W-1:0] rs_val = '0;
    logic [W-1:0] rt_val = '0;
    logic [W-1:0] result;
    logic         trap;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gp_int_alu #(.DATA_W(W)) i_gp_int_alu (
        .op_sel (op_sel),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .result (result),
        .trap   (trap)
    );

    function automatic logic [W-1:0] corner(input int i);
        case (i)
            0:  return 64'h0;
            1:  return 64'h1;
            2:  return 64'hFFFF_FFFF_FFFF_FFFF;
            3:  return 64'h8000_0000_0000_0000;
            4:  return 64'h7FFF_FFFF_FFFF_FFFF;
            5:  return 64'h0000_0000_8000_0000;
            6:  return 64'h0000_0000_7FFF_FFFF;
            7:  return 64'hFFFF_FFFF_0000_0000;
            8:  return 64'h0000_0000_FFFF_FFFF;
            9:  return 64'h1234_5678_9ABC_DEF0;
            10: return 64'hFEDC_BA98_7654_3210;
            default: return 64'hFFFF_FFFF_8000_0001;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd8: return "R5";
            4'd9: return "R6";
            4'd10: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic expect_out(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [31:0]  w;
        logic [W-1:0] exp_r;
        logic         exp_t;
        exp_t = 1'b0;
        case (op)
            4'd0: begin w = a[31:0] + b[31:0]; exp_r = {{32{w[31]}}, w}; end   // R1
            4'd1: begin w = a[31:0] - b[31:0]; exp_r = {{32{w[31]}}, w}; end   // R2
            4'd2: exp_r = a + b;                                               // R3
            4'd3: exp_r = a - b;
            4'd4: exp_r = a & b;                                               // R4
            4'd5: exp_r = a | b;
            4'd6: exp_r = a ^ b;
            4'd7: exp_r = ~(a | b);
            4'd8: exp_r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;           // R5
            4'd9: exp_r = (a < b) ? 64'd1 : 64'd0;                             // R6
            4'd10: begin exp_r = '0; exp_t = (a == b); end                     // R7
            default: exp_r = '0;                                               // R9
        endcase
        n_cmp++;
        if (result !== exp_r) begin
            n_bad++;
            $display("FAIL %s op=%0d rs=%h rt=%h result got %h expected %h",
                     req_of(op), op, a, b, result, exp_r);
        end
        n_cmp++;
        if (trap !== exp_t) begin
            n_bad++;
            $display("FAIL %s op=%0d rs=%h rt=%h trap got %b expected %b",
                     (op == 4'd10) ? "R7" : "R8", op, a, b, trap, exp_t);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // initial state: unused code with zero operands, R9
        @(negedge clk);
        expect_out(op_sel, rs_val, rt_val);
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    @(posedge clk);
                    op_sel = 4'(op);
                    rs_val = corner(i);
                    rt_val = corner(j);
                    @(negedge clk);
                    expect_out(op_sel, rs_val, rt_val);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule